// File: doc/BRIEF.md
# Zero-Suppressing Channel Readout Sequencer

This block is the digital back end of a sixteen-channel converter module. A conversion, modelled here as a parallel load of sixteen raw 11-bit values and a one-cycle done pulse, fills a channel store. The sequencer then offers those values on a 16-bit parallel output port. Before storing each value it can subtract a per-channel 8-bit pedestal. It can also drop channels that read zero and, if asked, channels that overflowed. When compression is on, a header word carrying the station number and the word count goes out first.

Several such modules share one port through a token chain. A module with data raises its request. Once its grant input is high it sends its words, and each word is moved with a strobe/acknowledge handshake. A module with nothing to send passes the grant straight on to the next module. A small host interface writes and reads the status register and the sixteen pedestals while no readout is pending. Two inputs stop the block at any time: a clear input aborts readout, and an initialize input aborts readout and also sets the eight control bits.

Top module: `zsq_readout`

## Requirements
- R1: Reset clears the status register and all pedestals. Status layout (bit numbers from 0): bits 7:0 station number, bit 8 pedestal subtraction enable, bit 9 compression enable, bit 10 port enable, bits 14:11 spare host bits, bit 15 overflow suppression. With `host_sel`=0, `host_rdata` returns the status register.
- R2: A pulse on `init` sets status bits 15:8 to 1 and keeps the station number. It also aborts any readout in the same way as `clr`.
- R3: With `host_sel`=1, `host_wr` writes `host_wdata[7:0]` into the pedestal of channel `host_addr`, and a read returns that pedestal zero-extended. A host write made while `req_out` is high has no effect.
- R4: With pedestal subtraction enabled, a raw value v other than 2047 is stored as v minus the pedestal, or as 0 if v is not above the pedestal. The overflow code 2047 is always stored unchanged. With subtraction disabled, raw values are stored as they are.
- R5: With compression disabled, exactly 16 data words are sent, for channel 0 up to channel 15, with no header. A data word is {1'b0, channel[3:0], value[10:0]}.
- R6: With compression enabled, the first word is a header {1'b1, count[3:0], 3'b000, station[7:0]}, where count is the number of data words that follow, taken modulo 16 (so 16 words give 0). Data words follow in ascending channel order, and channels whose stored value is 0 are left out.
- R7: An overflow word (stored value 2047) is left out only when both compression and overflow suppression are enabled.
- R8: One cycle after `conv_done`, `req_out` rises only if the port is enabled and at least one word will be sent. A `conv_done` pulse that arrives while `req_out` is high is ignored.
- R9: `pass_out` equals `ren_in` whenever no request is pending, and is 0 while `req_out` is high. The first strobe rises one cycle after `ren_in` is seen high with a request pending.
- R10: `wst_out` stays high, and `port_data` stays stable, until `wak_in` is sampled high. The strobe then falls on the next cycle.
- R11: After `wak_in` is sampled low, the next strobe rises exactly GAP_CYC clock edges later. The last word's acknowledge release ends the readout and drops `req_out`.
- R12: A pulse on `clr` drops `req_out` and `wst_out` on the next cycle and empties the store; no further words are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Abort readout and empty the store |
| init | input | 1 | Set control bits and abort readout |
| conv_done | input | 1 | One-cycle pulse: raw values are valid |
| conv_data | input | 176 | Sixteen raw 11-bit values, channel 0 in the low bits |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects status, 1 selects pedestal |
| host_addr | input | 4 | Pedestal channel |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| ren_in | input | 1 | Readout grant from upstream |
| pass_out | output | 1 | Grant passed downstream |
| req_out | output | 1 | Readout request |
| wst_out | output | 1 | Word strobe |
| wak_in | input | 1 | Word acknowledge |
| port_data | output | 16 | Output word, zero while the strobe is low |

## Verification
The hardest states to reach are those where the handshake and control paths interact. One is a clear that lands in the middle of a word sequence. Another is a second conversion or a host write arriving while a request waits for its grant. The bench reaches them by holding the grant low after a conversion, so the request stays pending while the extra conversion and writes are applied. For the abort, it raises the grant and watches the received word queue, applying the clear only after the header and one data word have arrived. The acknowledge delay and hold time change between readouts, so the gap timing is checked against different handshake rhythms.

// File: rtl/zsq_pkg.sv
package zsq_pkg;
    localparam int NCH    = 16;
    localparam int CH_W   = 4;
    localparam int VAL_W  = 11;
    localparam int PED_W  = 8;
    localparam int VSN_W  = 8;
    localparam int WORD_W = 16;
    localparam int CNT_W  = CH_W + 1;
    localparam logic [VAL_W-1:0] OVF_CODE = '1;

    typedef struct packed {
        logic             ovf_sup;
        logic [3:0]       spare;
        logic             port_en;
        logic             comp_en;
        logic             ped_en;
        logic [VSN_W-1:0] vsn;
    } stat_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_SEND,
        ST_REL,
        ST_GAP
    } rd_state_t;

    function automatic logic [WORD_W-1:0] hdr_word(input logic [CH_W-1:0] n,
                                                   input logic [VSN_W-1:0] vsn);
        return {1'b1, n, 3'b000, vsn};
    endfunction

    function automatic logic [WORD_W-1:0] dat_word(input logic [CH_W-1:0] ch,
                                                   input logic [VAL_W-1:0] val);
        return {1'b0, ch, val};
    endfunction
endpackage

// File: rtl/zsq_chan_proc.sv
module zsq_chan_proc
    import zsq_pkg::*;
(
    input  logic [VAL_W-1:0] raw,
    input  logic [PED_W-1:0] ped,
    input  logic             ped_en,
    input  logic             comp_en,
    input  logic             ovf_sup,
    output logic [VAL_W-1:0] val,
    output logic             keep
);
    logic             is_ovf;
    logic [VAL_W-1:0] ped_x;

    always_comb begin
        is_ovf = (raw == OVF_CODE);
        ped_x  = VAL_W'(ped);
        if (ped_en && !is_ovf)
            val = (raw > ped_x) ? (raw - ped_x) : '0;
        else
            val = raw;
        keep = !comp_en || ((val != '0) && !(ovf_sup && is_ovf));
    end
endmodule

// File: rtl/zsq_host_regs.sv
module zsq_host_regs
    import zsq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   init,
    input  logic                   wr_en,
    input  logic                   sel,
    input  logic [CH_W-1:0]        addr,
    input  logic [WORD_W-1:0]      wdata,
    output stat_t                  stat_o,
    output logic [NCH*PED_W-1:0]   peds_o,
    output logic [WORD_W-1:0]      rdata
);
    stat_t            stat_q;
    logic [PED_W-1:0] ped_q [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            for (int i = 0; i < NCH; i++) ped_q[i] <= '0;
        end else if (init) begin
            stat_q <= {8'hFF, stat_q.vsn};
        end else if (wr_en) begin
            if (sel) ped_q[addr] <= wdata[PED_W-1:0];
            else     stat_q      <= wdata;
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) peds_o[i*PED_W +: PED_W] = ped_q[i];
        stat_o = stat_q;
        rdata  = sel ? WORD_W'(ped_q[addr]) : WORD_W'(stat_q);
    end
endmodule

// File: rtl/zsq_pick.sv
module zsq_pick
    import zsq_pkg::*;
(
    input  logic [NCH-1:0]       mask,
    input  logic [NCH*VAL_W-1:0] vals,
    input  logic                 hdr_pend,
    input  logic [CH_W-1:0]      hdr_cnt,
    input  logic [VSN_W-1:0]     vsn,
    output logic [WORD_W-1:0]    word,
    output logic                 last
);
    logic [CH_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (mask[i]) sel = CH_W'(i);
        word = hdr_pend ? hdr_word(hdr_cnt, vsn)
                        : dat_word(sel, vals[int'(sel)*VAL_W +: VAL_W]);
        last = hdr_pend ? (mask == '0) : ((mask & (mask - NCH'(1))) == '0);
    end
endmodule

// File: rtl/zsq_readout.sv
module zsq_readout
    import zsq_pkg::*;
#(
    parameter int GAP_CYC = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   init,
    input  logic                   conv_done,
    input  logic [NCH*VAL_W-1:0]   conv_data,
    input  logic                   host_wr,
    input  logic                   host_sel,
    input  logic [CH_W-1:0]        host_addr,
    input  logic [WORD_W-1:0]      host_wdata,
    output logic [WORD_W-1:0]      host_rdata,
    input  logic                   ren_in,
    output logic                   pass_out,
    output logic                   req_out,
    output logic                   wst_out,
    input  logic                   wak_in,
    output logic [WORD_W-1:0]      port_data
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    stat_t                stat;
    logic [NCH*PED_W-1:0] peds;
    logic                 busy;
    rd_state_t            state;
    logic [NCH*VAL_W-1:0] new_val, val_q;
    logic [NCH-1:0]       new_keep, keep_q;
    logic [CNT_W-1:0]     new_cnt;
    logic [CH_W-1:0]      cnt_q;
    logic                 hdr_q;
    logic [GAP_W-1:0]     gap_cnt;
    logic [WORD_W-1:0]    cur_word;
    logic                 is_last;

    assign busy = (state != ST_IDLE);

    zsq_host_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .init   (init),
        .wr_en  (host_wr && !busy),
        .sel    (host_sel),
        .addr   (host_addr),
        .wdata  (host_wdata),
        .stat_o (stat),
        .peds_o (peds),
        .rdata  (host_rdata)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        zsq_chan_proc u_proc (
            .raw     (conv_data[ch*VAL_W +: VAL_W]),
            .ped     (peds[ch*PED_W +: PED_W]),
            .ped_en  (stat.ped_en),
            .comp_en (stat.comp_en),
            .ovf_sup (stat.ovf_sup),
            .val     (new_val[ch*VAL_W +: VAL_W]),
            .keep    (new_keep[ch])
        );
    end

    always_comb begin
        new_cnt = '0;
        for (int i = 0; i < NCH; i++) new_cnt = new_cnt + CNT_W'(new_keep[i]);
    end

    zsq_pick u_pick (
        .mask     (keep_q),
        .vals     (val_q),
        .hdr_pend (hdr_q),
        .hdr_cnt  (cnt_q),
        .vsn      (stat.vsn),
        .word     (cur_word),
        .last     (is_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            cnt_q <= '0;
        end else if (state == ST_IDLE && conv_done && !clr && !init) begin
            val_q <= new_val;
            cnt_q <= new_cnt[CH_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr || init) begin
            state   <= ST_IDLE;
            keep_q  <= '0;
            hdr_q   <= 1'b0;
            gap_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (conv_done) begin
                    keep_q <= new_keep;
                    hdr_q  <= stat.comp_en;
                    if (stat.port_en && new_cnt != '0) state <= ST_REQ;
                end
                ST_REQ:  if (ren_in) state <= ST_SEND;
                ST_SEND: if (wak_in) state <= ST_REL;
                ST_REL:  if (!wak_in) begin
                    if (hdr_q) hdr_q  <= 1'b0;
                    else       keep_q <= keep_q & (keep_q - NCH'(1));
                    gap_cnt <= '0;
                    state   <= is_last ? ST_IDLE : ST_GAP;
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_W'(GAP_CYC - 1)) state <= ST_SEND;
                    else gap_cnt <= gap_cnt + GAP_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_out   = busy;
        wst_out   = (state == ST_SEND);
        pass_out  = ren_in && !busy;
        port_data = wst_out ? cur_word : '0;
    end
endmodule

// File: rtl/zsq_readout_chk.sv
module zsq_readout_chk #(
    parameter int GAP_CYC = 5
) (
    input logic        clk,
    input logic        rst,
    input logic        clr,
    input logic        init,
    input logic        ren_in,
    input logic        wak_in,
    input logic        req_out,
    input logic        wst_out,
    input logic        pass_out,
    input logic [15:0] port_data,
    input logic [15:0] stat_q
);
    int   low_cnt;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst || !req_out) begin
            low_cnt <= 0;
            armed   <= 1'b0;
        end else if (wak_in) begin
            low_cnt <= 0;
            armed   <= 1'b1;
        end else if (!wst_out && low_cnt <= GAP_CYC) begin
            low_cnt <= low_cnt + 1;
        end
    end

    AST_PASS_EXCL: assert property (@(posedge clk) disable iff (rst) !(pass_out && req_out)); // R9
    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (rst) !req_out |-> (pass_out == ren_in)); // R9
    AST_WST_HOLD: assert property (@(posedge clk) disable iff (rst || clr || init) wst_out && !wak_in |=> wst_out); // R10
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst) wst_out && $past(wst_out) |-> $stable(port_data)); // R10
    AST_CLR_ABORT: assert property (@(posedge clk) disable iff (rst) clr |=> !req_out && !wst_out); // R12
    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (rst) $rose(req_out) |-> $past(stat_q[10])); // R8
    AST_STAT_LOCKED: assert property (@(posedge clk) disable iff (rst || init) req_out && !init |=> $stable(stat_q)); // R3
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst) $rose(wst_out) && armed |-> low_cnt > GAP_CYC); // R11
endmodule

bind zsq_readout zsq_readout_chk #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .init      (init),
    .ren_in    (ren_in),
    .wak_in    (wak_in),
    .req_out   (req_out),
    .wst_out   (wst_out),
    .pass_out  (pass_out),
    .port_data (port_data),
    .stat_q    (stat)
);

// File: tb/zsq_readout_tb.sv
module zsq_readout_tb;
    localparam int GAP = 5;

    logic          clk = 0;
    logic          rst = 1, clr = 0, init = 0, conv_done = 0;
    logic [175:0]  conv_data = '0;
    logic          host_wr = 0, host_sel = 0;
    logic [3:0]    host_addr = '0;
    logic [15:0]   host_wdata = '0, host_rdata;
    logic          ren_in = 0, pass_out, req_out, wst_out, wak_in;
    logic [15:0]   port_data;

    always #5 clk = ~clk;

    zsq_readout #(.GAP_CYC(GAP)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .init(init), .conv_done(conv_done),
        .conv_data(conv_data), .host_wr(host_wr), .host_sel(host_sel),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ren_in(ren_in), .pass_out(pass_out), .req_out(req_out), .wst_out(wst_out),
        .wak_in(wak_in), .port_data(port_data)
    );

    int total = 0, bad = 0;
    bit finished = 0;
    logic [15:0] exp_q[$], rx_q[$];
    logic [15:0] stm = '0;
    int  pedm [16];
    int  ra [16];
    logic exp_req = 0, nxt_req = 0, wak_q = 0;
    int  ack_dly = 1, ack_hold = 1;
    int  low_cnt = 0;
    bit  armed = 0, cap_on = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // reference: expected word list from the requirements
    task automatic calc();
        int n;
        logic [15:0] w[$];
        bit eps, ece, een, ofs;
        eps = stm[8]; ece = stm[9]; een = stm[10]; ofs = stm[15];
        n = 0;
        for (int ch = 0; ch < 16; ch++) begin
            int v;
            bit keep;
            v = ra[ch];
            if (eps && ra[ch] != 2047) v = (ra[ch] > pedm[ch]) ? ra[ch] - pedm[ch] : 0;
            keep = !ece || (v != 0 && !(ofs && ra[ch] == 2047));
            if (keep) begin
                w.push_back(16'((ch << 11) | v));
                n++;
            end
        end
        if (ece) w.push_front(16'h8000 | 16'((n % 16) << 11) | 16'(stm[7:0]));
        exp_q = w;
        nxt_req = een && (n > 0);
    endtask

    // behavioural reference of request timing
    always @(posedge clk) begin
        wak_q <= wak_in;
        if (rst || clr || init) exp_req <= 0;
        else if (!exp_req && conv_done) exp_req <= nxt_req;
        else if (exp_req && wak_q && !wak_in && rx_q.size() == exp_q.size()) exp_req <= 0;
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(req_out == exp_req, "R8 req", req_out, exp_req);
            chk(pass_out == (ren_in && !exp_req), "R9 pass", pass_out, ren_in && !exp_req);
            if (!exp_req) chk(wst_out == 0, "R12 no strobe when idle", wst_out, 0);
            if (wst_out && !cap_on) begin
                rx_q.push_back(port_data);
                if (armed) chk(low_cnt == GAP + 1, "R11 gap", low_cnt, GAP + 1);
                armed = 0;
            end
            cap_on = wst_out;
            if (wak_in) begin armed = 1; low_cnt = 0; end
            else if (!wst_out) low_cnt++;
            if (!exp_req) armed = 0;
        end
    end

    // acknowledge responder
    initial begin
        wak_in = 0;
        forever begin
            @(negedge clk);
            if (wst_out) begin
                repeat (ack_dly) @(posedge clk);
                #1 wak_in = 1;
                @(negedge clk);
                while (wst_out) @(negedge clk);
                repeat (ack_hold) @(posedge clk);
                #1 wak_in = 0;
            end
        end
    end

    task automatic hwr(input bit sel, input int addr, input int data);
        @(posedge clk); #1;
        host_wr = 1; host_sel = sel; host_addr = 4'(addr); host_wdata = 16'(data);
        @(posedge clk); #1;
        host_wr = 0;
    endtask

    task automatic hrd(input bit sel, input int addr, input int expv, input string tag);
        @(posedge clk); #1;
        host_sel = sel; host_addr = 4'(addr);
        @(negedge clk);
        chk(host_rdata == 16'(expv), tag, host_rdata, expv);
    endtask

    task automatic set_stat(input int v);
        hwr(0, 0, v);
        stm = 16'(v);
    endtask

    task automatic conv(input bit model);
        if (model && !exp_req) calc();
        @(posedge clk); #1;
        for (int ch = 0; ch < 16; ch++) conv_data[ch*11 +: 11] = 11'(ra[ch]);
        conv_done = 1;
        @(posedge clk); #1;
        conv_done = 0;
    endtask

    task automatic readout(input string tag);
        @(posedge clk); #1 ren_in = 1;
        @(negedge clk);
        while (exp_req) @(negedge clk);
        @(posedge clk); #1 ren_in = 0;
        chk(rx_q.size() == exp_q.size(), {tag, " word count"}, rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
            chk(rx_q[i] == exp_q[i], {tag, " word"}, rx_q[i], exp_q[i]);
        rx_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) pedm[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(req_out == 0 && wst_out == 0 && pass_out == 0, "R1 reset outputs", {req_out, wst_out, pass_out}, 0);
        hrd(0, 0, 0, "R1 status reset");
        hrd(1, 7, 0, "R1 pedestal reset");

        // R1 R3: status and pedestals
        set_stat(16'h045A);
        hrd(0, 0, 16'h045A, "R1 status readback");
        for (int i = 0; i < 16; i++) begin hwr(1, i, i * 3 + 20); pedm[i] = i * 3 + 20; end
        hrd(1, 0, 20, "R3 pedestal ch0");
        hrd(1, 15, 65, "R3 pedestal ch15");

        // R5: uncompressed, no subtraction
        for (int i = 0; i < 16; i++) ra[i] = (i * 61) % 1024;
        ra[4] = 2047;
        conv(1);
        readout("R5 plain");

        // R4: subtraction with saturation and overflow passthrough
        ack_dly = 2; ack_hold = 3;
        set_stat(16'h055A);
        for (int i = 0; i < 16; i++) ra[i] = 1000 - i * 40;
        ra[1] = 23; ra[2] = 26; ra[3] = 2047; ra[5] = 0;
        conv(1);
        readout("R4 pedestal");

        // R6 R7: compressed, overflow kept
        ack_dly = 1; ack_hold = 1;
        set_stat(16'h075A);
        for (int i = 0; i < 16; i++) ra[i] = (i % 3 == 0) ? 10 : 300 + i;
        ra[7] = 2047;
        conv(1);
        readout("R6 compressed");

        // R7: overflow suppressed
        set_stat(16'h875A);
        ra[8] = 2047;
        conv(1);
        readout("R7 overflow dropped");

        // R6: all sixteen words gives count 0
        ack_dly = 3; ack_hold = 2;
        set_stat(16'h0633);
        for (int i = 0; i < 16; i++) ra[i] = 500 + i;
        conv(1);
        readout("R6 full count");

        // R8 R9: compressed with nothing to send, grant passes
        for (int i = 0; i < 16; i++) ra[i] = 0;
        conv(1);
        @(posedge clk); #1 ren_in = 1;
        @(negedge clk);
        chk(pass_out == 1, "R9 empty passes grant", pass_out, 1);
        @(posedge clk); #1 ren_in = 0;
        exp_q.delete();

        // R8: port disabled
        set_stat(16'h0233);
        for (int i = 0; i < 16; i++) ra[i] = 100;
        conv(1);
        @(negedge clk);
        chk(req_out == 0, "R8 port disabled", req_out, 0);
        exp_q.delete();

        // R3 R8: writes and second conversion ignored while pending
        set_stat(16'h0412);
        for (int i = 0; i < 16; i++) ra[i] = 200 + i;
        conv(1);
        hwr(0, 0, 16'h0000);
        hwr(1, 3, 16'h00EE);
        hrd(0, 0, 16'h0412, "R3 status locked");
        hrd(1, 3, pedm[3], "R3 pedestal locked");
        for (int i = 0; i < 16; i++) ra[i] = 7;
        conv(0);
        readout("R8 second conversion ignored");

        // R12: clear mid readout
        ack_dly = 2; ack_hold = 2;
        set_stat(16'h0601);
        for (int i = 0; i < 16; i++) ra[i] = 50 + i;
        conv(1);
        @(posedge clk); #1 ren_in = 1;
        while (rx_q.size() < 2) @(negedge clk);
        @(posedge clk); #1 clr = 1;
        @(posedge clk); #1 clr = 0;
        @(negedge clk);
        chk(req_out == 0 && wst_out == 0, "R12 clear aborts", {req_out, wst_out}, 0);
        repeat (20) @(negedge clk);
        chk(rx_q.size() == 2, "R12 no words after clear", rx_q.size(), 2);
        for (int i = 0; i < 2; i++) chk(rx_q[i] == exp_q[i], "R12 prefix", rx_q[i], exp_q[i]);
        #1 ren_in = 0;
        while (wak_in) @(posedge clk);
        repeat (3) @(posedge clk);
        rx_q.delete(); exp_q.delete();

        // R2: init aborts and sets control bits
        set_stat(16'h045A);
        conv(1);
        @(posedge clk); #1 init = 1;
        @(posedge clk); #1 init = 0;
        @(negedge clk);
        chk(req_out == 0, "R2 init aborts", req_out, 0);
        stm = 16'hFF5A;
        hrd(0, 0, 16'hFF5A, "R2 init bits");
        exp_q.delete();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule